// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame begins with a low start bit. The data bits follow, least-significant first. An even parity bit is optional. The frame ends with a high stop interval of one, one and a half, or two bit times. The line idles high between frames.

A four-bit format input sets the shape of each frame:

| Bits | Meaning |
|------|---------|
| 1:0 | Character length |
| 2 | Long stop interval |
| 3 | Parity enable |

Timing comes from a baud enable tick that runs at sixteen times the bit rate. Every bit lasts a fixed number of these ticks.

The block has a one-entry holding register in front of a shift stage. A character written with the load strobe waits in the holding register until the shift stage is free. It then moves across, and the holding-empty flag rises again. This lets the next character be written while the current one is still going out, so frames can follow each other with no idle gap. The format is captured when a character moves into the shift stage. A frame therefore keeps the shape it started with, even if the format input changes while it is being sent.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `ser_out` is high and `hold_empty` is high, and no ticks are counted until a character has been loaded.
- R2: `line_fmt[1:0]` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low bits of the character are sent, least-significant first, and each lasts 16 baud ticks.
- R3: Each frame starts with a low start bit that lasts 16 baud ticks. The line goes low on the clock edge that moves the character into the shift stage.
- R4: With `line_fmt[2]` = 0, the stop interval is high for 16 ticks, whatever the word length.
- R5: With `line_fmt[2]` = 1 and a 5-bit word, the stop interval is high for 24 ticks.
- R6: With `line_fmt[2]` = 1 and a 6-, 7- or 8-bit word, the stop interval is high for 32 ticks.
- R7: With `line_fmt[3]` = 1, a 16-tick parity bit follows the data bits. Its value makes the count of ones over the sent data bits plus the parity bit even. Data bits above the word length have no effect on it. With `line_fmt[3]` = 0, no parity bit is sent.
- R8: `hold_empty` goes low one clock after `wr_stb`. It goes high on the edge that moves the character into the shift stage. When idle, that edge is the clock after the character was written. Otherwise it is the edge of the last stop tick, and the next start bit follows with no gap.
- R9: The format is captured when a frame begins. A change of `line_fmt` during a frame affects only the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Character to send |
| wr_stb | input | 1 | Writes `wr_data` into the holding register |
| baud_tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| line_fmt | input | 4 | Frame format: length [1:0], long stop [2], parity [3] |
| ser_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | High when the holding register can take a character |

## Verification
`hold_empty` is due low one clock after the strobe. When the transmitter is idle, the line falls and `hold_empty` rises one clock later still. The bench checks both at the falling edge after each of those rising edges.

After that, the line changes only on the edge that carries the last tick of a bit. The bench drives each tick itself and samples the line at the falling edge before every tick. Sample k therefore holds the level of tick k, which the bench compares with a per-tick frame it builds from the format arithmetic.

A second character is queued before any ticks run, and the format is changed after the first frame begins. This makes the stop length visible as the distance to the next start bit. It also shows the format being captured per frame and the exact tick at which `hold_empty` rises again.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // packed so that the bit positions match the format input: [3] parity, [2] long stop, [1:0] length
  typedef struct packed {
    logic       par_en;
    logic       stop_long;
    logic [1:0] len;
  } fmt_t;

  // number of data bits for a length code
  function automatic logic [3:0] word_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // stop interval in baud ticks: one, one and a half, or two bit times
  function automatic int unsigned stop_ticks(input fmt_t f, input int unsigned tpb);
    if (!f.stop_long)      return tpb;
    else if (f.len == 2'd0) return tpb + tpb / 2;
    else                   return 2 * tpb;
  endfunction

  // even parity over the selected low data bits only
  function automatic logic even_par(input logic [CHAR_MAX-1:0] d, input logic [1:0] len);
    logic p;
    p = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(word_bits(len))) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/aftx_holding.sv
module aftx_holding
  import aftx_pkg::*;
#(
  parameter int DATA_W = CHAR_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_stb) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> hold_full) else $error("holding register not full after write"); // R8

endmodule

// File: rtl/aftx_sequencer.sv
module aftx_sequencer
  import aftx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       hold_full,
  input  fmt_t       fmt_in,
  output logic       take,
  output phase_t     phase,
  output logic [2:0] bit_idx,
  output fmt_t       fmt_q
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] limit;
  logic             last_tick;
  logic             stop_done;
  logic             data_last;

  always_comb begin
    if (phase == PH_STOP) limit = CNT_W'(stop_ticks(fmt_q, TICKS_PER_BIT));
    else                  limit = CNT_W'(TICKS_PER_BIT);
  end

  assign last_tick = baud_tick && (tick_cnt == limit - 1'b1);
  assign stop_done = (phase == PH_STOP) && last_tick;
  assign data_last = ({1'b0, bit_idx} == word_bits(fmt_q.len) - 4'd1);
  assign take      = hold_full && ((phase == PH_IDLE) || stop_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      fmt_q    <= '0;
    end else if (take) begin
      phase    <= PH_START;
      tick_cnt <= '0;
      bit_idx  <= '0;
      fmt_q    <= fmt_in;
    end else if (baud_tick && phase != PH_IDLE) begin
      if (last_tick) begin
        tick_cnt <= '0;
        case (phase)
          PH_START: begin
            phase   <= PH_DATA;
            bit_idx <= '0;
          end
          PH_DATA: begin
            if (data_last) phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
            else           bit_idx <= bit_idx + 3'd1;
          end
          PH_PAR:  phase <= PH_STOP;
          default: phase <= PH_IDLE;
        endcase
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (tick_cnt < limit)) else $error("tick counter past bit limit"); // R3
  AST_IDX_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> ({1'b0, bit_idx} < word_bits(fmt_q.len))) else $error("data index beyond word"); // R2
  AST_HALF_STOP_LEN5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && limit != CNT_W'(TICKS_PER_BIT) && limit != CNT_W'(2 * TICKS_PER_BIT))
      |-> (fmt_q.len == 2'd0 && fmt_q.stop_long)) else $error("half stop outside 5-bit format"); // R5
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !take) |=> $stable(fmt_q)) else $error("format changed mid-frame"); // R9

endmodule

// File: rtl/aftx_line.sv
module aftx_line
  import aftx_pkg::*;
#(
  parameter int DATA_W = CHAR_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        fmt_len,
  input  phase_t            phase,
  input  logic [2:0]        bit_idx,
  output logic              ser_out
);

  logic [DATA_W-1:0] data_q;
  logic              par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (take) begin
      data_q <= hold_data;
      par_q  <= even_par(hold_data, fmt_len);
    end
  end

  always_comb begin
    case (phase)
      PH_START: ser_out = 1'b0;
      PH_DATA:  ser_out = data_q[bit_idx];
      PH_PAR:   ser_out = par_q;
      default:  ser_out = 1'b1;
    endcase
  end

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aftx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic       baud_tick,
  input  logic [3:0] line_fmt,
  output logic       ser_out,
  output logic       hold_empty
);

  logic       take;
  logic       hold_full;
  logic [7:0] hold_data;
  phase_t     phase;
  logic [2:0] bit_idx;
  fmt_t       fmt_q;
  fmt_t       fmt_in;

  assign fmt_in     = fmt_t'(line_fmt);
  assign hold_empty = !hold_full;

  aftx_holding #(.DATA_W(8)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  aftx_sequencer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .hold_full (hold_full),
    .fmt_in    (fmt_in),
    .take      (take),
    .phase     (phase),
    .bit_idx   (bit_idx),
    .fmt_q     (fmt_q)
  );

  aftx_line #(.DATA_W(8)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .hold_data (hold_data),
    .fmt_len   (fmt_in.len),
    .phase     (phase),
    .bit_idx   (bit_idx),
    .ser_out   (ser_out)
  );

  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ser_out) else $error("line not low after frame start"); // R3
  AST_EMPTY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_stb) |=> hold_empty) else $error("holding flag not empty after transfer"); // R8

endmodule

// File: tb/test_async_frame_tx.sv
module test_async_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_stb = 1'b0;
  logic       baud_tick = 1'b0;
  logic [3:0] line_fmt = '0;
  logic       ser_out;
  logic       hold_empty;

  always #5 clk = ~clk;

  async_frame_tx #(.TICKS_PER_BIT(16)) i_async_frame_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data    (wr_data),
    .wr_stb     (wr_stb),
    .baud_tick  (baud_tick),
    .line_fmt   (line_fmt),
    .ser_out    (ser_out),
    .hold_empty (hold_empty)
  );

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  logic exp_t [0:599];
  logic got_t [0:599];
  logic he_t  [0:599];
  int   n_exp;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t[n_exp] = v;
      n_exp++;
    end
  endtask

  function automatic int stop_len(input logic [3:0] f);
    int nb;
    nb = 5 + int'(f[1:0]);
    if (!f[2]) return 16;
    return (nb == 5) ? 24 : 32;
  endfunction

  task automatic add_frame(input logic [7:0] d, input logic [3:0] f);
    int   nb;
    logic p;
    nb = 5 + int'(f[1:0]);
    p  = 1'b0;
    push(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      push(d[i], 16);
      p = p ^ d[i];
    end
    if (f[3]) push(p, 16);
    push(1'b1, stop_len(f));
  endtask

  task automatic cmp_seg(input int lo, input int hi, input string tag, input string what);
    int bad;
    bad = -1;
    for (int k = lo; k < hi; k++) begin
      if (bad < 0 && got_t[k] !== exp_t[k]) bad = k;
    end
    chk(bad < 0, tag, $sformatf("%s (tick %0d)", what, bad),
        (bad < 0) ? 0 : int'(got_t[bad]), (bad < 0) ? 0 : int'(exp_t[bad]));
  endtask

  task automatic run(input logic [7:0] d1, input logic [7:0] d2, input logic [3:0] f1, input logic [3:0] f2);
    int    nb, len1, s_par, s_stop;
    string stag;
    nb     = 5 + int'(f1[1:0]);
    s_par  = 16 + 16 * nb;
    s_stop = s_par + (f1[3] ? 16 : 0);
    n_exp  = 0;
    add_frame(d1, f1);
    len1 = n_exp;
    add_frame(d2, f2);
    push(1'b1, 16);
    line_fmt = f1;
    // first character: written while idle
    @(negedge clk); wr_data = d1; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    chk(hold_empty == 1'b0, "R8", "empty flag one clock after write", int'(hold_empty), 0);
    @(negedge clk);
    chk(hold_empty == 1'b1 && ser_out == 1'b0, "R3", "transfer: line low and flag high",
        int'({hold_empty, ser_out}), 2);
    // second character queued behind the running frame, then the format changes
    wr_data = d2; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    chk(hold_empty == 1'b0, "R8", "flag low while queued", int'(hold_empty), 0);
    line_fmt = f2;
    for (int k = 0; k < n_exp; k++) begin
      @(negedge clk);
      got_t[k] = ser_out;
      he_t[k]  = hold_empty;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    if (!f1[2])          stag = "R4";
    else if (nb == 5)    stag = "R5";
    else                 stag = "R6";
    cmp_seg(0, 16, "R3", "start bit");
    cmp_seg(16, s_par, "R2", "data bits");
    if (f1[3]) cmp_seg(s_par, s_stop, "R7", "parity bit");
    cmp_seg(s_stop, len1, stag, "stop interval");
    cmp_seg(len1, n_exp, "R9", "second frame with new format");
    chk(he_t[len1-1] == 1'b0 && he_t[len1] == 1'b1, "R8", "flag rises at back-to-back transfer",
        int'({he_t[len1-1], he_t[len1]}), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got 0 expected 1 finished run");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hB4; pats[3] = 8'h6B;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b1 && hold_empty == 1'b1, "R1", "line and flag in reset", int'({ser_out, hold_empty}), 3);
    rst_n = 1'b1;
    // ticks with nothing loaded must leave the line idle
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); baud_tick = 1'b1;
      @(negedge clk); baud_tick = 1'b0;
    end
    chk(ser_out == 1'b1 && hold_empty == 1'b1, "R1", "idle after unloaded ticks", int'({ser_out, hold_empty}), 3);
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d2;
        d2 = {pats[p][3:0], pats[p][7:4]} ^ 8'h3C;
        run(pats[p], d2, 4'(f), 4'(f) ^ 4'b1011);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule